// File: doc/BRIEF.md
# Serial Control Word Loader with Amplifier Sequencing

This block takes an 80-bit configuration word over two wires, a serial clock and a combined data/strobe line, and keeps the active copy that configures a transceiver. Bits are shifted into a staging register while the active copy stays unchanged. A level change on the data/strobe line while the serial clock is high commits the staged word. The commit raises a one-cycle load pulse, and the new mode takes effect at once.

The block also drives a power-amplifier enable with a counted ramp. When a transmit word is committed, the amplifier starts ramping up only after the serial clock has gone low and the PLL lock indication is present. When a commit arrives while the amplifier is on, the amplifier is ramped down first. The staged word is committed only once the ramp reaches zero. A sticky flag reports a serial clock that falls too soon after a commit. Both serial inputs are resynchronised into the system clock domain. The lock input is taken as already synchronous.

Top module: `ctrlword_loader`

## Requirements
- R1: On each rising edge of the serial clock, the level of the data/strobe line is shifted into the staging register at bit 0, and earlier bits move one place toward bit 79. The first bit sent therefore ends up in bit 79.
- R2: A level change in either direction on the data/strobe line while the serial clock is high, with the amplifier fully off, copies the staging register to `cfg_o` and raises `load_pulse_o` for exactly one system clock.
- R3: `cfg_o` does not change when bits are shifted, or when the data/strobe line changes while the serial clock is low.
- R4: `mode_o` is bits [1:0] of the committed word: 00 power-down, 01 receive, 10 transmit, 11 standby. It updates in the same cycle as `cfg_o`.
- R5: After a transmit word is committed, `pa_en_o` stays low while the serial clock remains high.
- R6: `pa_en_o` rises only while `lock_i` is high, after the serial clock has gone low following a transmit commit. With `lock_i` low, the amplifier stays fully off.
- R7: A commit request made while `pa_en_o` is high or `pa_level_o` is nonzero first drops `pa_en_o`. `cfg_o` is held until `pa_level_o` reaches 0, and only then does the commit and its load pulse occur.
- R8: `pa_level_o` moves by at most one step per system clock, toward `RAMP_LEN` when `pa_en_o` is high and toward 0 when it is low. `pa_full_on_o` is high exactly at `RAMP_LEN` and `pa_full_off_o` exactly at 0.
- R9: `timing_viol_o` is set when the serial clock falls fewer than `MIN_GAP` system clocks after a commit. It stays set until the next commit clears it.
- R10: After reset, `cfg_o` is 0, `mode_o` is power-down, `pa_level_o` is 0 with `pa_full_off_o` high, and `load_pulse_o`, `pa_en_o` and `timing_viol_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data and commit strobe (asynchronous) |
| lock_i | input | 1 | PLL lock indication, synchronous |
| cfg_o | output | WORD_W | Active configuration word |
| mode_o | output | 2 | Active mode field |
| load_pulse_o | output | 1 | One-cycle commit pulse |
| pa_en_o | output | 1 | Amplifier ramp target (on/off) |
| pa_level_o | output | LVL_W | Amplifier ramp level |
| pa_full_on_o | output | 1 | Ramp at full level |
| pa_full_off_o | output | 1 | Ramp at zero |
| timing_viol_o | output | 1 | Serial clock fell too soon after a commit |

## Verification
A staging register that shifts in the wrong order, or a commit that fires on the wrong edge, shows up on `cfg_o` and `mode_o` within a few system clocks of the strobe change. A sequencer in the wrong state shows as `pa_en_o` rising with lock low or while the serial clock is still high, or as a load pulse arriving before the ramp has drained. The ramp counter appears directly on `pa_level_o` within `RAMP_LEN` cycles. A wrong gap count shows on `timing_viol_o` at the first serial clock fall after a commit.

// File: rtl/ctrlword_pkg.sv
// Package: shared types for the control word loader.
// Assumes the mode field sits in bits [1:0] of the committed word.
package ctrlword_pkg;
    typedef enum logic [1:0] {
        MODE_PDOWN   = 2'b00,
        MODE_RECV    = 2'b01,
        MODE_XMIT    = 2'b10,
        MODE_STANDBY = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'b00,
        SEQ_DRAIN     = 2'b01,
        SEQ_WAIT_LOW  = 2'b10,
        SEQ_WAIT_LOCK = 2'b11
    } seq_state_e;

    localparam int MODE_LSB = 0;
endpackage

// File: rtl/bit_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherency is implied.
module bit_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First flop samples the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Further flops let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_frontend.sv
// Serial front end: resynchronises the serial clock and data/strobe line,
// detects edges, shifts the staging register and raises commit requests.
// Assumes the serial clock is well below the system clock rate, with each
// phase lasting at least STAGES+1 system clocks.
module ser_frontend #(
    parameter int WORD_W = 80,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    output logic [WORD_W-1:0] stage_o,
    output logic              commit_req_o,
    output logic              sck_low_o,
    output logic              sck_fall_o
);
    logic [1:0] sync_w;
    logic       sck_s, dat_s, sck_prev_q, dat_prev_q;
    logic       sck_rise;
    logic [WORD_W-1:0] stage_q;

    bit_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ser_dat_i}),
        .sync_o  (sync_w)
    );

    assign sck_s = sync_w[1];
    assign dat_s = sync_w[0];

    // Previous synchronised samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            dat_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            dat_prev_q <= dat_s;
        end
    end

    assign sck_rise     = sck_s & ~sck_prev_q;
    assign sck_fall_o   = ~sck_s & sck_prev_q;
    assign sck_low_o    = ~sck_s;
    assign commit_req_o = sck_s & sck_prev_q & (dat_s ^ dat_prev_q);

    // Staging shift register, first bit lands in the top position.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (sck_rise) stage_q <= {stage_q[WORD_W-2:0], dat_s};
    end

    assign stage_o = stage_q;

    a_r1_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(stage_q));
    a_r1_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> stage_q[0] == $past(dat_s));
endmodule

// File: rtl/pa_sequencer.sv
// Amplifier sequencer: decides when a commit may fire, drains the ramp
// before committing over an active amplifier, waits for a low serial clock
// and lock before ramping up, and times the gap after each commit.
// Assumes lock_i is synchronous to clk.
module pa_sequencer
    import ctrlword_pkg::*;
#(
    parameter int RAMP_LEN = 8,
    parameter int MIN_GAP  = 8,
    localparam int LVL_W   = $clog2(RAMP_LEN + 1),
    localparam int GAP_W   = $clog2(MIN_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_req_i,
    input  logic             sck_low_i,
    input  logic             sck_fall_i,
    input  logic             lock_i,
    input  logic             new_is_xmit_i,
    output logic             fire_o,
    output logic             pa_en_o,
    output logic [LVL_W-1:0] pa_level_o,
    output logic             timing_viol_o
);
    seq_state_e       state_q, state_d;
    logic             target_q, target_d;
    logic [LVL_W-1:0] level_q;
    logic [GAP_W-1:0] gap_q;
    logic             armed_q, viol_q;
    logic             pa_busy, fire;

    assign pa_busy = target_q | (level_q != '0);

    // Next-state and commit decision.
    always_comb begin
        state_d  = state_q;
        target_d = target_q;
        fire     = 1'b0;
        case (state_q)
            SEQ_DRAIN: begin
                if (level_q == '0) begin
                    fire    = 1'b1;
                    state_d = new_is_xmit_i ? SEQ_WAIT_LOW : SEQ_IDLE;
                end
            end
            SEQ_WAIT_LOW: begin
                if (commit_req_i) begin
                    fire    = 1'b1;
                    state_d = new_is_xmit_i ? SEQ_WAIT_LOW : SEQ_IDLE;
                end else if (sck_low_i) begin
                    state_d = SEQ_WAIT_LOCK;
                end
            end
            SEQ_WAIT_LOCK: begin
                if (commit_req_i) begin
                    fire    = 1'b1;
                    state_d = new_is_xmit_i ? SEQ_WAIT_LOW : SEQ_IDLE;
                end else if (lock_i) begin
                    target_d = 1'b1;
                    state_d  = SEQ_IDLE;
                end
            end
            default: begin
                if (commit_req_i) begin
                    if (pa_busy) begin
                        target_d = 1'b0;
                        state_d  = SEQ_DRAIN;
                    end else begin
                        fire    = 1'b1;
                        state_d = new_is_xmit_i ? SEQ_WAIT_LOW : SEQ_IDLE;
                    end
                end
            end
        endcase
    end

    // State and ramp target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            target_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
        end
    end

    // Ramp counter moving one step per clock toward the target.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (target_q && level_q != LVL_W'(RAMP_LEN))
            level_q <= level_q + 1'b1;
        else if (!target_q && level_q != '0)
            level_q <= level_q - 1'b1;
    end

    // Gap timer and sticky violation flag after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
            viol_q  <= 1'b0;
        end else if (fire) begin
            gap_q   <= '0;
            armed_q <= 1'b1;
            viol_q  <= 1'b0;
        end else begin
            if (gap_q != GAP_W'(MIN_GAP)) gap_q <= gap_q + 1'b1;
            if (sck_fall_i && armed_q) begin
                armed_q <= 1'b0;
                if (gap_q < GAP_W'(MIN_GAP)) viol_q <= 1'b1;
            end
        end
    end

    assign fire_o        = fire;
    assign pa_en_o       = target_q;
    assign pa_level_o    = level_q;
    assign timing_viol_o = viol_q;

    a_r7_fire_pa_off: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (level_q == '0) && !target_q);
    a_r6_lock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(target_q) |-> $past(lock_i));
    a_r8_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1)
                 || (level_q == $past(level_q) - 1'b1));
    a_r8_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(RAMP_LEN));
    a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_q) |-> $past(sck_fall_i));
endmodule

// File: rtl/ctrlword_loader.sv
// Top: serial control word loader with amplifier sequencing. Holds the
// active configuration word and publishes amplifier ramp status.
// Assumes serial phases are slow compared with clk (see ser_frontend).
module ctrlword_loader
    import ctrlword_pkg::*;
#(
    parameter int WORD_W   = 80,
    parameter int STAGES   = 2,
    parameter int RAMP_LEN = 8,
    parameter int MIN_GAP  = 8,
    localparam int LVL_W   = $clog2(RAMP_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              lock_i,
    output logic [WORD_W-1:0] cfg_o,
    output logic [1:0]        mode_o,
    output logic              load_pulse_o,
    output logic              pa_en_o,
    output logic [LVL_W-1:0]  pa_level_o,
    output logic              pa_full_on_o,
    output logic              pa_full_off_o,
    output logic              timing_viol_o
);
    logic [WORD_W-1:0] stage_w;
    logic              commit_req_w, sck_low_w, sck_fall_w, fire_w;
    logic [WORD_W-1:0] cfg_q;
    logic              pulse_q;
    op_mode_e          staged_mode;

    ser_frontend #(.WORD_W(WORD_W), .STAGES(STAGES)) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk_i    (ser_clk_i),
        .ser_dat_i    (ser_dat_i),
        .stage_o      (stage_w),
        .commit_req_o (commit_req_w),
        .sck_low_o    (sck_low_w),
        .sck_fall_o   (sck_fall_w)
    );

    assign staged_mode = op_mode_e'(stage_w[MODE_LSB +: 2]);

    pa_sequencer #(.RAMP_LEN(RAMP_LEN), .MIN_GAP(MIN_GAP)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_req_i  (commit_req_w),
        .sck_low_i     (sck_low_w),
        .sck_fall_i    (sck_fall_w),
        .lock_i        (lock_i),
        .new_is_xmit_i (staged_mode == MODE_XMIT),
        .fire_o        (fire_w),
        .pa_en_o       (pa_en_o),
        .pa_level_o    (pa_level_o),
        .timing_viol_o (timing_viol_o)
    );

    // Active register and the load pulse that accompanies its update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire_w;
            if (fire_w) cfg_q <= stage_w;
        end
    end

    assign cfg_o         = cfg_q;
    assign mode_o        = cfg_q[MODE_LSB +: 2];
    assign load_pulse_o  = pulse_q;
    assign pa_full_on_o  = (pa_level_o == LVL_W'(RAMP_LEN));
    assign pa_full_off_o = (pa_level_o == '0);

    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_w |=> $stable(cfg_q));
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pa_full_on_o, pa_full_off_o}));
    a_r5_no_en_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> !pa_en_o);
endmodule

// File: tb/ctrlword_loader_tb.sv
module ctrlword_loader_tb;
    localparam int W = 80;
    localparam int RL = 8;
    localparam int LW = $clog2(RL + 1);
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic sdat = 1'b0;
    logic lock = 1'b0;
    logic [W-1:0] cfg;
    logic [1:0] mode;
    logic pulse, pa_en, full_on, full_off, viol;
    logic [LW-1:0] level;

    int n_checks = 0;
    int n_fail = 0;
    int n_pulses = 0;
    int cycles = 0;

    ctrlword_loader #(.WORD_W(W), .STAGES(2), .RAMP_LEN(RL), .MIN_GAP(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdat),
        .lock_i(lock), .cfg_o(cfg), .mode_o(mode), .load_pulse_o(pulse),
        .pa_en_o(pa_en), .pa_level_o(level), .pa_full_on_o(full_on),
        .pa_full_off_o(full_off), .timing_viol_o(viol)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && pulse) n_pulses <= n_pulses + 1;
    end

    localparam logic [W-1:0] VEC [6] = '{
        80'h0123_4567_89AB_CDEF_0011,
        80'hFEDC_BA98_7654_3210_AA52,
        80'hA5A5_5A5A_F00F_0FF0_1234,
        80'h8000_0000_0000_0000_0003,
        80'h7FFF_FFFF_FFFF_FFFF_FFFE,
        80'hDEAD_BEEF_CAFE_F00D_5551
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdat = b; tick(HALF);
        sck = 1'b1; tick(HALF);
        sck = 1'b0; tick(HALF);
    endtask

    // Sends bits 79..1; the caller finishes bit 0.
    task automatic send_head(input logic [W-1:0] w);
        for (int i = W - 1; i >= 1; i--) send_bit(w[i]);
    endtask

    // Full word; with commit, the line toggles while the clock is high,
    // and the clock falls 'gap' cycles later.
    task automatic send_word(input logic [W-1:0] w, input bit commit, input int gap);
        send_head(w);
        if (!commit) begin
            send_bit(w[0]);
        end else begin
            sdat = w[0]; tick(HALF);
            sck = 1'b1; tick(HALF);
            sdat = ~w[0]; tick(gap);
            sck = 1'b0; tick(HALF);
        end
    endtask

    initial begin
        int p0;
        logic [W-1:0] prev;
        // R10: reset state
        tick(3);
        sample;
        chk("R10 cfg", cfg, '0);
        chk("R10 mode", W'(mode), W'(2'b00));
        chk("R10 pulse/en/viol", W'({pulse, pa_en, viol}), '0);
        chk("R10 level", W'(level), '0);
        chk("R10 full_off", W'(full_off), W'(1));
        rst_n = 1'b1;
        tick(2);

        // R3: shift a whole word with no commit, then toggle while clock low
        p0 = n_pulses;
        send_word(80'h1111_2222_3333_4444_5556, 1'b0, 0);
        sdat = ~sdat; tick(HALF);
        sdat = ~sdat; tick(HALF * 2);
        sample;
        chk("R3 cfg held", cfg, '0);
        chk("R3 no pulse", W'(n_pulses - p0), '0);

        // R5/R6: transmit commit with lock low
        p0 = n_pulses;
        send_head(80'h1111_2222_3333_4444_5556);
        sdat = 1'b0; tick(HALF);
        sck = 1'b1; tick(HALF);
        sdat = 1'b1; tick(20);
        sample;
        chk("R1/R2 cfg committed", cfg, 80'h1111_2222_3333_4444_5556);
        chk("R4 mode transmit", W'(mode), W'(2'b10));
        chk("R2 one pulse", W'(n_pulses - p0), W'(1));
        chk("R5 pa_en low while clock high", W'(pa_en), '0);
        sck = 1'b0; tick(30);
        sample;
        chk("R6 no ramp without lock", W'({pa_en, full_off}), W'(2'b01));
        lock = 1'b1; tick(3);
        sample;
        chk("R8 mid ramp", W'((level > 0) && (level < RL)), W'(1));
        tick(20);
        sample;
        chk("R6/R8 full on", W'({pa_en, full_on, level}), W'({2'b11, LW'(RL)}));
        chk("R9 no violation", W'(viol), '0);

        // R7: leave transmit; commit deferred until the ramp drains
        prev = cfg;
        p0 = n_pulses;
        send_head(80'h0F0F_0F0F_0F0F_0F0F_0F00);
        sdat = 1'b0; tick(HALF);
        sck = 1'b1; tick(HALF);
        sdat = 1'b1; tick(5);
        sample;
        chk("R7 pa_en dropped", W'(pa_en), '0);
        chk("R7 cfg held during drain", cfg, prev);
        chk("R7 no early pulse", W'(n_pulses - p0), '0);
        tick(30);
        sck = 1'b0; tick(10);
        sample;
        chk("R7 cfg after drain", cfg, 80'h0F0F_0F0F_0F0F_0F0F_0F00);
        chk("R7 one pulse", W'(n_pulses - p0), W'(1));
        chk("R4 mode power-down", W'(mode), W'(2'b00));
        chk("R8 full off", W'(full_off), W'(1));

        // Vector table: each word committed with a legal gap, lock held high
        for (int v = 0; v < 6; v++) begin
            p0 = n_pulses;
            send_word(VEC[v], 1'b1, 30);
            tick(30);
            sample;
            chk("R1/R2 vector cfg", cfg, VEC[v]);
            chk("R4 vector mode", W'(mode), W'(VEC[v][1:0]));
            chk("R2 vector pulse", W'(n_pulses - p0), W'(1));
            chk("R6 vector full_on", W'(full_on), W'(VEC[v][1:0] == 2'b10));
            chk("R9 vector no viol", W'(viol), '0);
        end

        // R9: clock falls one cycle after the commit
        send_word(80'h0000_0000_0000_0000_0041, 1'b1, 1);
        tick(10);
        sample;
        chk("R9 violation set", W'(viol), W'(1));
        chk("R9 commit still made", cfg, 80'h0000_0000_0000_0000_0041);
        send_word(80'h0000_0000_0000_0000_0081, 1'b1, 30);
        tick(10);
        sample;
        chk("R9 violation cleared", W'(viol), '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule